// File: doc/BRIEF.md
# Digital VCO with Round-Robin Phase Distributor

This block is the modulator stage of a multi-phase buck controller. It sits between the compensator and the on-time generators. A signed compensator word sets the rate of a numerically controlled oscillator. A higher word gives more events per unit time, so each PWM firing comes earlier. A lower word gives fewer events, so each firing comes later. No fixed sawtooth carrier is used.

Each clock, the oscillator adds an increment to a phase accumulator. The increment is a base rate plus the compensator word times a programmable gain, scaled by a fixed right shift. The sum is clamped into a programmable range. The base rate sets the steady-state event rate, which is N times the nominal per-phase switching frequency. The gain comes from outside, so software can scale it with the phase count, the switching frequency and the inverse of the output voltage.

Every accumulator wrap is one firing event. A one-hot rotating pointer hands each event to the start strobe of the next active phase. A windowed event counter reports how many events occurred in each fixed measurement window. A slow frequency-lock loop uses this count.

Top module: `dvco_phase_dist`

## Requirements
- R1: The increment is base_inc_i + ((comp_i × gain_i) >>> MUL_SHIFT). In this expression comp_i is two's complement, gain_i is unsigned, and the shift is arithmetic. The result is clamped to the range 0 to max_inc_i.
- R2: Every clock adds the increment to an ACC_W-bit accumulator, modulo 2^ACC_W. fire_o is high for exactly the one cycle that follows each clock edge at which the sum carried out.
- R3: With gain_i above zero and the other inputs fixed, a larger comp_i gives at least as many fire events over an interval. A clearly larger comp_i gives strictly more.
- R4: If the unclamped increment is negative, the increment is 0 and fire_o stays low.
- R5: If the unclamped increment exceeds max_inc_i, the increment equals max_inc_i. For example, max_inc_i = 2^ACC_W/4 fires exactly once every 4 cycles.
- R6: phase_strobe_o has exactly one bit set in each cycle where fire_o is high, and no bit set otherwise. Bit i is the start strobe of phase i.
- R7: Successive events go to phases 0, 1, …, N−1, and then wrap back to phase 0.
- R8: The effective N is n_phases_i, with two exceptions: 0 counts as 1, and values above MAX_PH count as MAX_PH. If N shrinks so that the pointer lies outside the active phases, the next event goes to phase 0.
- R9: While rst_ni is low, the accumulator and the outputs are 0 and the pointer sits on phase 0.
- R10: After reset, evt_valid_o pulses high for one cycle once every WIN_LEN cycles. At each pulse, evt_count_o updates to the number of cycles with fire_o high among the WIN_LEN cycles before that pulse. evt_count_o holds that value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| comp_i | input | COMP_W | Signed compensator word |
| gain_i | input | GAIN_W | Unsigned oscillator gain |
| base_inc_i | input | ACC_W | Nominal increment (N × nominal switching rate) |
| max_inc_i | input | ACC_W | Upper clamp of the increment |
| n_phases_i | input | PH_SEL_W | Number of active phases |
| fire_o | output | 1 | One-cycle firing event |
| phase_strobe_o | output | MAX_PH | Per-phase start strobe, one-hot on an event |
| evt_count_o | output | CNT_W | Events counted in the last window |
| evt_valid_o | output | 1 | Pulses when evt_count_o updates |

## Verification
The bench builds the block with ACC_W=16, COMP_W=12, GAIN_W=12, MUL_SHIFT=6, MAX_PH=8 and WIN_LEN=64. These sizes make an accumulator wrap happen within a few cycles, and give a full measurement window every 64 cycles. Long random runs therefore exercise both clamp limits, many rotations of the pointer, and many window boundaries. A gain of 64 with a shift of 6 makes the scaled term equal to comp_i, so the directed rate cases can be computed by hand. The bench also drives n_phases_i values of 0 and above 8. It shrinks N while the pointer sits high, which exercises the R8 redirection.

// File: rtl/dvco_pkg.sv
`timescale 1ns/1ps
package dvco_pkg;
  localparam int DEF_ACC_W    = 24;
  localparam int DEF_COMP_W   = 12;
  localparam int DEF_GAIN_W   = 16;
  localparam int DEF_SHIFT    = 10;
  localparam int DEF_MAX_PH   = 8;
  localparam int DEF_WIN_LEN  = 4096;

  function automatic int unsigned eff_phases(input int unsigned n, input int unsigned max_ph);
    if (n == 0) return 1;
    if (n > max_ph) return max_ph;
    return n;
  endfunction
endpackage

// File: rtl/dvco_inc_calc.sv
`timescale 1ns/1ps
module dvco_inc_calc #(
  parameter int ACC_W     = 24,
  parameter int COMP_W    = 12,
  parameter int GAIN_W    = 16,
  parameter int MUL_SHIFT = 10
) (
  input  logic [COMP_W-1:0] comp_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [ACC_W-1:0]  base_inc_i,
  input  logic [ACC_W-1:0]  max_inc_i,
  output logic [ACC_W-1:0]  inc_o
);
  localparam int PROD_W = COMP_W + GAIN_W + 1;
  localparam int SUM_W  = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 2;

  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  prod_x, base_x, max_x, sum;

  always_comb begin
    prod   = $signed({{(GAIN_W+1){comp_i[COMP_W-1]}}, comp_i})
           * $signed({{(COMP_W+1){1'b0}}, gain_i});
    prod_x = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
    base_x = $signed({{(SUM_W-ACC_W){1'b0}}, base_inc_i});
    max_x  = $signed({{(SUM_W-ACC_W){1'b0}}, max_inc_i});
    sum    = base_x + (prod_x >>> MUL_SHIFT);
    if (sum < 0)          inc_o = '0;
    else if (sum > max_x) inc_o = max_inc_i;
    else                  inc_o = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/dvco_accum.sv
`timescale 1ns/1ps
module dvco_accum #(
  parameter int ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  output logic             fire_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      fire_o <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/dvco_phase_rot.sv
`timescale 1ns/1ps
module dvco_phase_rot #(
  parameter int MAX_PH   = 8,
  parameter int PH_SEL_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_i,
  input  logic [PH_SEL_W-1:0] n_phases_i,
  output logic [MAX_PH-1:0]   strobe_o
);
  logic [PH_SEL_W-1:0] n_eff;
  logic [MAX_PH-1:0]   ptr_q, act_mask, top_mask, eff_ptr, nxt_ptr;

  always_comb begin
    if (n_phases_i == '0)                          n_eff = PH_SEL_W'(1);
    else if (n_phases_i > PH_SEL_W'(MAX_PH))       n_eff = PH_SEL_W'(MAX_PH);
    else                                           n_eff = n_phases_i;
  end

  for (genvar i = 0; i < MAX_PH; i++) begin : g_mask
    assign act_mask[i] = (n_eff > PH_SEL_W'(i));
    assign top_mask[i] = (n_eff == PH_SEL_W'(i + 1));
  end

  // pointer outside the active set is redirected to phase 0
  assign eff_ptr = (|(ptr_q & act_mask)) ? ptr_q : MAX_PH'(1);
  if (MAX_PH > 1) begin : g_shift
    assign nxt_ptr = (|(eff_ptr & top_mask)) ? MAX_PH'(1) : {eff_ptr[MAX_PH-2:0], 1'b0};
  end else begin : g_single
    assign nxt_ptr = MAX_PH'(1);
  end
  assign strobe_o = fire_i ? eff_ptr : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= MAX_PH'(1);
    else if (fire_i) ptr_q <= nxt_ptr;
  end
endmodule

// File: rtl/dvco_evt_count.sv
`timescale 1ns/1ps
module dvco_evt_count #(
  parameter int WIN_LEN = 4096,
  parameter int CNT_W   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  localparam int WC_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [WC_W-1:0]  wcnt_q;
  logic [CNT_W-1:0] acc_q;
  logic             last;

  assign last = (wcnt_q == WC_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      acc_q   <= '0;
      count_o <= '0;
      valid_o <= 1'b0;
    end else if (last) begin
      wcnt_q  <= '0;
      acc_q   <= '0;
      count_o <= acc_q + CNT_W'(fire_i);
      valid_o <= 1'b1;
    end else begin
      wcnt_q  <= wcnt_q + WC_W'(1);
      acc_q   <= acc_q + CNT_W'(fire_i);
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dvco_phase_dist.sv
`timescale 1ns/1ps
module dvco_phase_dist #(
  parameter int ACC_W     = dvco_pkg::DEF_ACC_W,
  parameter int COMP_W    = dvco_pkg::DEF_COMP_W,
  parameter int GAIN_W    = dvco_pkg::DEF_GAIN_W,
  parameter int MUL_SHIFT = dvco_pkg::DEF_SHIFT,
  parameter int MAX_PH    = dvco_pkg::DEF_MAX_PH,
  parameter int WIN_LEN   = dvco_pkg::DEF_WIN_LEN,
  localparam int PH_SEL_W = $clog2(MAX_PH + 1),
  localparam int CNT_W    = $clog2(WIN_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [COMP_W-1:0]   comp_i,
  input  logic [GAIN_W-1:0]   gain_i,
  input  logic [ACC_W-1:0]    base_inc_i,
  input  logic [ACC_W-1:0]    max_inc_i,
  input  logic [PH_SEL_W-1:0] n_phases_i,
  output logic                fire_o,
  output logic [MAX_PH-1:0]   phase_strobe_o,
  output logic [CNT_W-1:0]    evt_count_o,
  output logic                evt_valid_o
);
  logic [ACC_W-1:0] inc;

  dvco_inc_calc #(.ACC_W(ACC_W), .COMP_W(COMP_W), .GAIN_W(GAIN_W), .MUL_SHIFT(MUL_SHIFT)) u_inc (
    .comp_i(comp_i), .gain_i(gain_i), .base_inc_i(base_inc_i), .max_inc_i(max_inc_i), .inc_o(inc)
  );

  dvco_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc), .fire_o(fire_o)
  );

  dvco_phase_rot #(.MAX_PH(MAX_PH), .PH_SEL_W(PH_SEL_W)) u_rot (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire_o), .n_phases_i(n_phases_i), .strobe_o(phase_strobe_o)
  );

  dvco_evt_count #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire_o), .count_o(evt_count_o), .valid_o(evt_valid_o)
  );
endmodule

// File: rtl/dvco_phase_dist_chk.sv
`timescale 1ns/1ps
module dvco_phase_dist_chk #(
  parameter int MAX_PH   = 8,
  parameter int WIN_LEN  = 4096,
  parameter int PH_SEL_W = 4,
  parameter int CNT_W    = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [PH_SEL_W-1:0] n_phases_i,
  input logic                fire_o,
  input logic [MAX_PH-1:0]   phase_strobe_o,
  input logic [CNT_W-1:0]    evt_count_o,
  input logic                evt_valid_o
);
  logic [MAX_PH-1:0]   last_q, exp_next;
  logic [PH_SEL_W-1:0] n_at_q;
  logic                has_q;
  int unsigned         ne;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      n_at_q <= '0;
      has_q  <= 1'b0;
    end else if (fire_o) begin
      last_q <= phase_strobe_o;
      n_at_q <= n_phases_i;
      has_q  <= 1'b1;
    end
  end

  always_comb begin
    ne = dvco_pkg::eff_phases(int'(n_at_q), MAX_PH);
    exp_next = '0;
    if (last_q[ne-1]) exp_next[0] = 1'b1;
    else              exp_next = last_q << 1;
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $onehot(phase_strobe_o)) else $error("strobe not one-hot on event"); // R6
  AST_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_o |-> (phase_strobe_o == '0)) else $error("strobe without event"); // R6
  AST_ROUND_ROBIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && has_q && (n_phases_i == n_at_q)) |-> (phase_strobe_o == exp_next))
    else $error("phase order broken"); // R7
  AST_ACTIVE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (phase_strobe_o < (MAX_PH'(1) << (dvco_pkg::eff_phases(int'(n_phases_i), MAX_PH) - 1)) * 2))
    else $error("strobe outside active phases"); // R8
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o) else $error("valid longer than one cycle"); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_count_o <= CNT_W'(WIN_LEN)) else $error("count exceeds window"); // R10
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_o |=> (evt_valid_o || $stable(evt_count_o))) else $error("count moved between windows"); // R10
endmodule

bind dvco_phase_dist dvco_phase_dist_chk #(
  .MAX_PH(MAX_PH), .WIN_LEN(WIN_LEN), .PH_SEL_W(PH_SEL_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .n_phases_i(n_phases_i), .fire_o(fire_o),
  .phase_strobe_o(phase_strobe_o), .evt_count_o(evt_count_o), .evt_valid_o(evt_valid_o)
);

// File: tb/dvco_phase_dist_bench.sv
`timescale 1ns/1ps
module dvco_phase_dist_bench;
  localparam int ACC_W = 16, COMP_W = 12, GAIN_W = 12, SHIFT = 6, MAX_PH = 8, WIN = 64;
  localparam int PSW = $clog2(MAX_PH + 1), CW = $clog2(WIN + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [COMP_W-1:0] comp = '0;
  logic [GAIN_W-1:0] gain = '0;
  logic [ACC_W-1:0]  base = '0, mx = '0;
  logic [PSW-1:0]    nph = '0;
  logic fire, valid;
  logic [MAX_PH-1:0] strobe;
  logic [CW-1:0] cnt;

  int checks = 0, fails = 0;
  bit chk_en = 0, done = 0;

  always #2 clk = ~clk;

  dvco_phase_dist #(.ACC_W(ACC_W), .COMP_W(COMP_W), .GAIN_W(GAIN_W), .MUL_SHIFT(SHIFT),
                    .MAX_PH(MAX_PH), .WIN_LEN(WIN)) u_dvco_phase_dist (
    .clk_i(clk), .rst_ni(rst_n), .comp_i(comp), .gain_i(gain), .base_inc_i(base),
    .max_inc_i(mx), .n_phases_i(nph), .fire_o(fire), .phase_strobe_o(strobe),
    .evt_count_o(cnt), .evt_valid_o(valid));

  function automatic longint exp_inc(input logic [ACC_W-1:0] b, input logic [COMP_W-1:0] c,
                                     input logic [GAIN_W-1:0] g, input logic [ACC_W-1:0] m);
    longint p, s;
    p = longint'($signed(c)) * longint'(g);
    p = p >>> SHIFT;
    s = longint'(b) + p;
    if (s < 0) return 0;
    if (s > longint'(m)) return longint'(m);
    return s;
  endfunction

  function automatic int n_eff(input int n);
    return (n == 0) ? 1 : ((n > MAX_PH) ? MAX_PH : n);
  endfunction

  // reference model
  longint m_acc; bit m_fire; int m_idx, m_wcnt, m_cnt, m_evt; bit m_valid;
  longint t_sum; int t_ne, t_e;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_fire = 0; m_idx = 0; m_wcnt = 0; m_cnt = 0; m_evt = 0; m_valid = 0;
    end else begin
      t_ne = n_eff(int'(nph));
      t_e  = (m_idx < t_ne) ? m_idx : 0;
      if (m_fire) m_idx = (t_e == t_ne - 1) ? 0 : t_e + 1;
      if (m_wcnt == WIN - 1) begin
        m_evt = m_cnt + int'(m_fire); m_cnt = 0; m_wcnt = 0; m_valid = 1;
      end else begin
        m_cnt = m_cnt + int'(m_fire); m_wcnt++; m_valid = 0;
      end
      t_sum = m_acc + exp_inc(base, comp, gain, mx);
      m_fire = (t_sum >= (64'sd1 << ACC_W));
      m_acc = t_sum % (64'sd1 << ACC_W);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  logic [MAX_PH-1:0] e_str;
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      t_ne = n_eff(int'(nph));
      e_str = m_fire ? (MAX_PH'(1) << ((m_idx < t_ne) ? m_idx : 0)) : '0;
      check(fire == m_fire, "R2 fire", fire, m_fire);
      check(strobe == e_str, "R6/R7 strobe", strobe, e_str);
      check(valid == m_valid, "R10 valid", valid, m_valid);
      check(cnt == CW'(m_evt), "R10 count", cnt, m_evt);
    end
  end

  task automatic drive(input logic [COMP_W-1:0] c, input logic [GAIN_W-1:0] g,
                       input logic [ACC_W-1:0] b, input logic [ACC_W-1:0] m, input int n);
    @(posedge clk); #1;
    comp = c; gain = g; base = b; mx = m; nph = PSW'(n);
  endtask

  task automatic count_fires(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      n += int'(fire);
    end
  endtask

  int lo, hi, nf;
  initial begin
    void'($urandom(32'd1729));
    #1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(fire == 1'b0, "R9 fire in reset", fire, 0);
    check(strobe == '0, "R9 strobe in reset", strobe, 0);
    check(cnt == '0 && valid == 1'b0, "R9 count in reset", cnt, 0);
    @(posedge clk); #1; rst_n = 1'b1; chk_en = 1;

    // R1/R3: gain 64 with shift 6 gives scaled term equal to comp
    drive(COMP_W'(-500), 64, 1000, 20000, 4);
    count_fires(655, lo);
    drive(COMP_W'(500), 64, 1000, 20000, 4);
    count_fires(655, hi);
    check(hi > lo, "R3 rate rises with comp", hi, lo + 1);
    check(lo >= 4 && lo <= 6, "R1 low rate", lo, 5);
    check(hi >= 14 && hi <= 16, "R1 high rate", hi, 15);

    // R4: negative increment clamps to zero
    drive(COMP_W'(-2048), 4095, 10, 20000, 3);
    count_fires(200, nf);
    check(nf == 0, "R4 no fire at zero increment", nf, 0);

    // R5: upper clamp gives one event per 4 cycles
    drive(COMP_W'(2047), 4095, 100, 16384, 3);
    count_fires(200, nf);
    check(nf == 50, "R5 clamp rate", nf, 50);

    // R8: n=0 acts as one phase, n=12 as MAX_PH
    drive(COMP_W'(0), 0, 16384, 16384, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (fire) check(strobe == 8'h01, "R8 n=0 single phase", strobe, 1);
    end
    drive(COMP_W'(0), 0, 16384, 16384, 12);
    repeat (80) @(negedge clk);

    // R8: shrink N while pointer is on phase 5
    drive(COMP_W'(0), 0, 16384, 16384, 8);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (strobe == 8'h20) break;
    end
    @(posedge clk); #1; nph = PSW'(3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (fire) begin
        check(strobe == 8'h01, "R8 redirect to phase 0", strobe, 1);
        break;
      end
    end

    // random segments
    for (int s = 0; s < 40; s++) begin
      drive(COMP_W'($urandom), GAIN_W'($urandom), ACC_W'($urandom_range(0, 30000)),
            ACC_W'($urandom_range(0, 65535)), int'($urandom_range(0, 10)));
      repeat ($urandom_range(60, 300)) @(negedge clk);
    end

    chk_en = 0;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: finished=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule